// File: doc/BRIEF.md
# Radio Event Timer with Period Counter and Frame Capture

This block keeps link-layer time for a low-energy radio. A 16-bit sub-period counter runs from zero up to a programmable period value and then restarts, and every restart advances a 24-bit period counter. The two counters together give a 40-bit timestamp: the period count is the upper 24 bits and the sub-period count is the lower 16 bits. When the radio reports a start-of-frame or an end-of-transmit strobe, the whole timestamp is copied into a 40-bit capture register. Firmware can then read the exact moment of that event.

Two sub-period compare values and two period compare values produce single-cycle pulses when the counters reach them. Each pulse goes either to the radio receive/transmit start outputs or to the interrupt line, as a per-source route bit selects. Every pulse also sets a sticky flag. The counters run only while a run bit is set. While the timer is stopped, firmware can load both counters directly. A read of the low count copies the period count into a shadow register, so a 40-bit timestamp can be read safely in two accesses.

Register map (4-bit address, 32-bit data, read data valid one cycle after `rd_en`): 0 control (bit 0 = run), 1 period, 2 low count, 3 high count (shadow on read), 4 capture low 16 bits, 5 capture high 24 bits, 6 low compare 0, 7 low compare 1, 8 period compare 0, 9 period compare 1, 10 flags, 11 route.

Top module: `radio_evt_timer`

## Requirements
- R1: After reset the counters, capture, compares, route, flags and run bit are zero, the period register reads 0xFFFF, `rdata` is 0 and `rx_start`, `tx_start`, `irq` are low.
- R2: While run is set, the low count advances by one per clock. When the low count is at or above the period value, it returns to 0 on the next clock and the high count advances by one, so the low count visits 0..period.
- R3: A high level on `sof_evt` or `eot_evt` at a clock edge stores {high count, low count}, as held just before that edge, in the capture register (addresses 4 and 5). Without a strobe the capture register keeps its value.
- R4: Each low compare (addresses 6, 7) gives a one-cycle hit in the cycle the running low count takes the compare value.
- R5: Each period compare (addresses 8, 9) gives a one-cycle hit in the cycle the high count advances to the compare value.
- R6: Route bit 0 sends low compare 0 hits, and route bit 2 sends period compare 0 hits, to `rx_start`. Route bits 1 and 3 do the same for the compare 1 sources and `tx_start`. A source whose route bit is 0 drives no radio output and is reported through `irq` instead.
- R7: A read of address 2 returns the low count and copies the high count into a shadow register. A read of address 3 returns the shadow, so the pair is one coherent 40-bit value even while counting.
- R8: Flags (address 10) are sticky: bit 0 low compare 0, bit 1 low compare 1, bit 2 period compare 0, bit 3 period compare 1, bit 4 period-count wrap. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. `irq` is high while any of bits 0..3 is set with its route bit 0, or bit 4 is set.
- R9: When the high count passes from 0xFFFFFF to 0, flag bit 4 is set.
- R10: Counting happens only while control bit 0 is 1. Writes to addresses 2 and 3 load the counters while stopped and are ignored while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_evt | input | 1 | Start-of-frame strobe |
| eot_evt | input | 1 | End-of-transmit strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| rx_start | output | 1 | Receive start pulse |
| tx_start | output | 1 | Transmit start pulse |
| irq | output | 1 | Interrupt request level |

## Verification
If the sub-period counter holds a wrong value, the error shows up in the next readback. It also appears as hits that arrive at the wrong moment, and it spreads into the period count at the next period boundary, at most period+1 cycles later. A wrong shadow or capture register shows only at the next read of the high half or the capture addresses. The bench therefore reads those halves after each run and compares them with a timestamp it computes itself. If a sticky flag is lost, or a route bit is wrong, `irq` is wrong within one cycle of the hit, and the count of radio start pulses differs from the number of compare visits the bench works out for the run.

// File: rtl/evt_timer_pkg.sv
`timescale 1ns/1ps
package evt_timer_pkg;
  localparam int ADDR_W  = 4;
  localparam int NUM_CMP = 2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 4'd1;
  localparam logic [ADDR_W-1:0] A_LOW    = 4'd2;
  localparam logic [ADDR_W-1:0] A_HIGH   = 4'd3;
  localparam logic [ADDR_W-1:0] A_CAPL   = 4'd4;
  localparam logic [ADDR_W-1:0] A_CAPH   = 4'd5;
  localparam logic [ADDR_W-1:0] A_CMP0   = 4'd6;
  localparam logic [ADDR_W-1:0] A_CMP1   = 4'd7;
  localparam logic [ADDR_W-1:0] A_OVC0   = 4'd8;
  localparam logic [ADDR_W-1:0] A_OVC1   = 4'd9;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd10;
  localparam logic [ADDR_W-1:0] A_ROUTE  = 4'd11;
endpackage

// File: rtl/evt_rst_sync.sv
`timescale 1ns/1ps
module evt_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/evt_timebase.sv
`timescale 1ns/1ps
module evt_timebase #(
  parameter int LO_W = 16,
  parameter int HI_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [LO_W-1:0] period,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic [LO_W-1:0] ld_val_lo,
  input  logic [HI_W-1:0] ld_val_hi,
  output logic [LO_W-1:0] lo_q,
  output logic [HI_W-1:0] hi_q,
  output logic [LO_W-1:0] lo_nxt,
  output logic [HI_W-1:0] hi_nxt,
  output logic            hi_adv,
  output logic            hi_wrap
);
  logic tb_en;

  always_comb begin
    lo_nxt  = lo_q;
    hi_nxt  = hi_q;
    hi_adv  = 1'b0;
    hi_wrap = 1'b0;
    if (run) begin
      if (lo_q >= period) begin
        lo_nxt            = '0;
        hi_adv            = 1'b1;
        {hi_wrap, hi_nxt} = {1'b0, hi_q} + (HI_W+1)'(1);
      end else begin
        lo_nxt = lo_q + 1'b1;
      end
    end else begin
      if (ld_lo) lo_nxt = ld_val_lo;
      if (ld_hi) hi_nxt = ld_val_hi;
    end
  end

  assign tb_en = run | ld_lo | ld_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (tb_en) begin
      lo_q <= lo_nxt;
      hi_q <= hi_nxt;
    end
  end

  // R2: a running counter at or past the period restarts and carries
  a_r2_period_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && lo_q >= period) |=> (lo_q == '0 && hi_q == $past(hi_q) + 1'b1));

  // R10: stopped and not loaded means nothing moves
  a_r10_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_lo && !ld_hi) |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/evt_match.sv
`timescale 1ns/1ps
module evt_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] nxt,
  input  logic [W-1:0] ref_val,
  output logic         hit
);
  logic hit_d;

  assign hit_d = adv & (nxt == ref_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= hit_d;
  end
endmodule

// File: rtl/radio_evt_timer.sv
`timescale 1ns/1ps
module radio_evt_timer
  import evt_timer_pkg::*;
#(
  parameter int LO_W = 16,
  parameter int HI_W = 24,
  parameter int DATA_W = 32,
  parameter logic [LO_W-1:0] PERIOD_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_evt,
  input  logic              eot_evt,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rx_start,
  output logic              tx_start,
  output logic              irq
);
  localparam int TS_W     = LO_W + HI_W;
  localparam int NSRC     = 2 * NUM_CMP;
  localparam int NF       = NSRC + 1;
  localparam int WRAP_BIT = NSRC;

  logic              rst_sn;
  logic              run_q, run_d;
  logic [LO_W-1:0]   period_q, period_d;
  logic [LO_W-1:0]   cmp_lo_q [NUM_CMP];
  logic [LO_W-1:0]   cmp_lo_d [NUM_CMP];
  logic [HI_W-1:0]   cmp_hi_q [NUM_CMP];
  logic [HI_W-1:0]   cmp_hi_d [NUM_CMP];
  logic [NSRC-1:0]   route_q, route_d;
  logic [NF-1:0]     flags_q, flags_d, set_vec, clr_vec;
  logic [TS_W-1:0]   cap_q;
  logic [HI_W-1:0]   shadow_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [LO_W-1:0]   lo_q, lo_nxt;
  logic [HI_W-1:0]   hi_q, hi_nxt;
  logic              hi_adv, hi_wrap;
  logic [NUM_CMP-1:0] lo_hit, hi_hit;
  logic              ld_lo, ld_hi, cap_en, shadow_en;
  logic              unused_wdata_bits;

  evt_rst_sync i_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sn));

  evt_timebase #(.LO_W(LO_W), .HI_W(HI_W)) i_tb (
    .clk(clk), .rst_n(rst_sn), .run(run_q), .period(period_q),
    .ld_lo(ld_lo), .ld_hi(ld_hi),
    .ld_val_lo(wdata[LO_W-1:0]), .ld_val_hi(wdata[HI_W-1:0]),
    .lo_q(lo_q), .hi_q(hi_q), .lo_nxt(lo_nxt), .hi_nxt(hi_nxt),
    .hi_adv(hi_adv), .hi_wrap(hi_wrap));

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    evt_match #(.W(LO_W)) i_lo (
      .clk(clk), .rst_n(rst_sn), .adv(run_q), .nxt(lo_nxt),
      .ref_val(cmp_lo_q[g]), .hit(lo_hit[g]));
    evt_match #(.W(HI_W)) i_hi (
      .clk(clk), .rst_n(rst_sn), .adv(hi_adv), .nxt(hi_nxt),
      .ref_val(cmp_hi_q[g]), .hit(hi_hit[g]));
  end

  assign ld_lo     = wr_en && (addr == A_LOW)  && !run_q;
  assign ld_hi     = wr_en && (addr == A_HIGH) && !run_q;
  assign cap_en    = sof_evt | eot_evt;
  assign shadow_en = rd_en && (addr == A_LOW);
  assign set_vec   = {hi_wrap, hi_hit, lo_hit};
  assign unused_wdata_bits = ^wdata[DATA_W-1:HI_W];

  // write decode, next state
  always_comb begin
    run_d    = run_q;
    period_d = period_q;
    route_d  = route_q;
    clr_vec  = '0;
    for (int i = 0; i < NUM_CMP; i++) begin
      cmp_lo_d[i] = cmp_lo_q[i];
      cmp_hi_d[i] = cmp_hi_q[i];
    end
    if (wr_en) begin
      case (addr)
        A_CTRL:   run_d       = wdata[0];
        A_PERIOD: period_d    = wdata[LO_W-1:0];
        A_CMP0:   cmp_lo_d[0] = wdata[LO_W-1:0];
        A_CMP1:   cmp_lo_d[1] = wdata[LO_W-1:0];
        A_OVC0:   cmp_hi_d[0] = wdata[HI_W-1:0];
        A_OVC1:   cmp_hi_d[1] = wdata[HI_W-1:0];
        A_FLAGS:  clr_vec     = wdata[NF-1:0];
        A_ROUTE:  route_d     = wdata[NSRC-1:0];
        default:  ;
      endcase
    end
    flags_d = (flags_q & ~clr_vec) | set_vec;
  end

  // read mux, next state
  always_comb begin
    case (addr)
      A_CTRL:   rdata_d = DATA_W'(run_q);
      A_PERIOD: rdata_d = DATA_W'(period_q);
      A_LOW:    rdata_d = DATA_W'(lo_q);
      A_HIGH:   rdata_d = DATA_W'(shadow_q);
      A_CAPL:   rdata_d = DATA_W'(cap_q[LO_W-1:0]);
      A_CAPH:   rdata_d = DATA_W'(cap_q[TS_W-1:LO_W]);
      A_CMP0:   rdata_d = DATA_W'(cmp_lo_q[0]);
      A_CMP1:   rdata_d = DATA_W'(cmp_lo_q[1]);
      A_OVC0:   rdata_d = DATA_W'(cmp_hi_q[0]);
      A_OVC1:   rdata_d = DATA_W'(cmp_hi_q[1]);
      A_FLAGS:  rdata_d = DATA_W'(flags_q);
      A_ROUTE:  rdata_d = DATA_W'(route_q);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      run_q    <= 1'b0;
      period_q <= PERIOD_RST;
      route_q  <= '0;
      flags_q  <= '0;
      cap_q    <= '0;
      shadow_q <= '0;
      rdata_q  <= '0;
      for (int i = 0; i < NUM_CMP; i++) begin
        cmp_lo_q[i] <= '0;
        cmp_hi_q[i] <= '0;
      end
    end else begin
      if (wr_en) begin
        run_q    <= run_d;
        period_q <= period_d;
        route_q  <= route_d;
        for (int i = 0; i < NUM_CMP; i++) begin
          cmp_lo_q[i] <= cmp_lo_d[i];
          cmp_hi_q[i] <= cmp_hi_d[i];
        end
      end
      flags_q <= flags_d;
      if (cap_en)    cap_q    <= {hi_q, lo_q};
      if (shadow_en) shadow_q <= hi_q;
      if (rd_en)     rdata_q  <= rdata_d;
    end
  end

  assign rdata    = rdata_q;
  assign rx_start = (lo_hit[0] & route_q[0]) | (hi_hit[0] & route_q[NUM_CMP]);
  assign tx_start = (lo_hit[1] & route_q[1]) | (hi_hit[1] & route_q[NUM_CMP+1]);
  assign irq      = (|(flags_q[NSRC-1:0] & ~route_q)) | flags_q[WRAP_BIT];

  // R3: a frame strobe stores the timestamp seen at that edge
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_sn)
    (sof_evt || eot_evt) |=> (cap_q == $past({hi_q, lo_q})));

  // R3: without a strobe the captured value holds
  a_r3_capture_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    (!sof_evt && !eot_evt) |=> $stable(cap_q));

  // R7: a low-half read copies the high count into the shadow
  a_r7_shadow: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_en && addr == A_LOW) |=> (shadow_q == $past(hi_q)));

  // R8: every hit or wrap event leaves its flag set
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_sn)
    (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

  // R6: a radio start pulse is always backed by a raised flag
  a_r6_rx_flagged: assert property (@(posedge clk) disable iff (!rst_sn)
    rx_start |=> (flags_q[0] || flags_q[NUM_CMP]));

  // R9: leaving the top of the period count raises the wrap flag
  a_r9_wrap_flag: assert property (@(posedge clk) disable iff (!rst_sn)
    hi_wrap |=> flags_q[WRAP_BIT]);
endmodule

// File: tb/test_radio_evt_timer.sv
`timescale 1ns/1ps
module test_radio_evt_timer;
  import evt_timer_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof_evt = 1'b0, eot_evt = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_start, tx_start, irq;

  int checks = 0;
  int failures = 0;
  int rx_cnt = 0;
  int tx_cnt = 0;

  radio_evt_timer i_radio_evt_timer (
    .clk(clk), .rst_n(rst_n), .sof_evt(sof_evt), .eot_evt(eot_evt),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rx_start(rx_start), .tx_start(tx_start), .irq(irq));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rx_start) rx_cnt++;
    if (tx_start) tx_cnt++;
  end

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic strobe(input bit eot);
    if (eot) eot_evt = 1'b1; else sof_evt = 1'b1;
    @(negedge clk);
    eot_evt = 1'b0; sof_evt = 1'b0;
  endtask

  // Expected state after n running cycles, from the requirement text.
  task automatic model(input int p, input int l0, input int h0, input int n,
                       input logic [3:0] rt, input int c0, input int c1,
                       input int o0, input int o1,
                       output int lo, output int hi, output int rxn,
                       output int txn, output logic [4:0] fl);
    lo = l0; hi = h0; rxn = 0; txn = 0; fl = '0;
    for (int k = 1; k <= n; k++) begin
      bit lh0, lh1, hh0, hh1;
      lh0 = 0; lh1 = 0; hh0 = 0; hh1 = 0;
      if (lo >= p) begin
        lo = 0;
        hi = (hi + 1) & 32'hFF_FFFF;
        if (hi == 0) fl[4] = 1'b1;
        hh0 = (hi == o0);
        hh1 = (hi == o1);
      end else begin
        lo = lo + 1;
      end
      lh0 = (lo == c0);
      lh1 = (lo == c1);
      if (lh0) fl[0] = 1'b1;
      if (lh1) fl[1] = 1'b1;
      if (hh0) fl[2] = 1'b1;
      if (hh1) fl[3] = 1'b1;
      if ((lh0 && rt[0]) || (hh0 && rt[2])) rxn++;
      if ((lh1 && rt[1]) || (hh1 && rt[3])) txn++;
    end
  endtask

  task automatic scenario(input string tag, input int p, input int l0, input int h0,
                          input int c0, input int c1, input int o0, input int o1,
                          input logic [3:0] rt, input int m);
    logic [31:0] v;
    int elo, ehi, erx, etx;
    logic [4:0] efl;
    wr(A_PERIOD, p); wr(A_LOW, l0); wr(A_HIGH, h0);
    wr(A_CMP0, c0); wr(A_CMP1, c1); wr(A_OVC0, o0); wr(A_OVC1, o1);
    wr(A_ROUTE, {28'd0, rt}); wr(A_FLAGS, 32'h1F);
    idle(2);
    rx_cnt = 0; tx_cnt = 0;
    wr(A_CTRL, 1);
    idle(m);
    wr(A_CTRL, 0);
    idle(3);
    model(p, l0, h0, m + 1, rt, c0, c1, o0, o1, elo, ehi, erx, etx, efl);
    rd(A_LOW, v);   chk({tag, " R2 low count"}, v, elo);
    rd(A_HIGH, v);  chk({tag, " R2 high count"}, v, ehi);
    chk({tag, " R4 R6 rx_start pulses"}, rx_cnt, erx);
    chk({tag, " R5 R6 tx_start pulses"}, tx_cnt, etx);
    rd(A_FLAGS, v); chk({tag, " R8 flags"}, v, efl);
    chk({tag, " R8 irq"}, irq, (|(efl[3:0] & ~rt)) | efl[4]);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int elo, ehi, erx, etx;
    logic [4:0] efl;
    void'($urandom(32'd20110128));
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 rx_start", rx_start, 0);
    chk("R1 tx_start", tx_start, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rdata", rdata, 0);
    rd(A_CTRL, v);   chk("R1 run bit", v, 0);
    rd(A_PERIOD, v); chk("R1 period", v, 32'hFFFF);
    rd(A_LOW, v);    chk("R1 low", v, 0);
    rd(A_HIGH, v);   chk("R1 high", v, 0);
    rd(A_FLAGS, v);  chk("R1 flags", v, 0);
    rd(A_CAPH, v);   chk("R1 capture", v, 0);

    // R10 loads while stopped
    wr(A_LOW, 32'h1234); rd(A_LOW, v); chk("R10 stopped load low", v, 32'h1234);
    wr(A_HIGH, 32'h00BEEF); rd(A_LOW, v); rd(A_HIGH, v);
    chk("R10 stopped load high", v, 32'h00BEEF);

    // R10 write ignored while running: 8 increments from 0 with period 9
    wr(A_PERIOD, 9); wr(A_LOW, 0); wr(A_HIGH, 0);
    wr(A_CTRL, 1); idle(3); wr(A_LOW, 7); idle(3); wr(A_CTRL, 0);
    rd(A_LOW, v);  chk("R10 running write ignored", v, 8);
    rd(A_CTRL, v); chk("R10 run bit cleared", v, 0);

    // R2 directed wrap at period 4
    scenario("dir_p4", 4, 2, 5, 100, 100, 1000, 1000, 4'b0000, 11);

    // R9 period count wraps to zero, then R8 write-one-to-clear
    scenario("R9 wrap", 3, 3, 32'hFF_FFFF, 0, 0, 0, 0, 4'b0000, 0);
    rd(A_FLAGS, v); chk("R9 wrap flag bit4", v[4], 1);
    wr(A_FLAGS, 32'h01); rd(A_FLAGS, v); chk("R8 clear one bit", v, 32'h1E);
    chk("R8 irq still high", irq, 1);
    wr(A_FLAGS, 32'h1E); rd(A_FLAGS, v); chk("R8 cleared all", v, 0);
    chk("R8 irq low", irq, 0);

    // R4 R5 R6 directed compares and routing
    scenario("dir_cmp", 5, 0, 0, 3, 5, 2, 7, 4'b0101, 20);
    wr(A_FLAGS, 32'h02); rd(A_FLAGS, v); chk("R8 remaining sticky", v, 32'h05);
    chk("R6 routed flags keep irq low", irq, 0);

    // R7 coherent two-part read with period 2
    wr(A_PERIOD, 2); wr(A_LOW, 0); wr(A_HIGH, 0);
    wr(A_CTRL, 1); idle(5);
    rd(A_LOW, v);
    model(2, 0, 0, 5, 4'b0, -1, -1, -1, -1, elo, ehi, erx, etx, efl);
    chk("R7 low at read", v, elo);
    idle(7);
    rd(A_HIGH, v); chk("R7 shadow high", v, ehi);
    wr(A_CTRL, 0);
    rd(A_HIGH, v); chk("R7 shadow unchanged", v, ehi);
    model(2, 0, 0, 15, 4'b0, -1, -1, -1, -1, elo, ehi, erx, etx, efl);
    rd(A_LOW, v);  chk("R7 final low", v, elo);
    rd(A_HIGH, v); chk("R7 final high", v, ehi);

    // R3 capture on start-of-frame while running
    wr(A_LOW, 0); wr(A_HIGH, 0);
    wr(A_CTRL, 1); idle(4); strobe(0); wr(A_CTRL, 0);
    model(2, 0, 0, 4, 4'b0, -1, -1, -1, -1, elo, ehi, erx, etx, efl);
    rd(A_CAPL, v); chk("R3 sof capture low", v, elo);
    rd(A_CAPH, v); chk("R3 sof capture high", v, ehi);
    // R3 capture on end-of-transmit while stopped
    wr(A_LOW, 1); wr(A_HIGH, 32'hABCDEF); strobe(1);
    rd(A_CAPL, v); chk("R3 eot capture low", v, 1);
    rd(A_CAPH, v); chk("R3 eot capture high", v, 32'hABCDEF);
    wr(A_LOW, 7); idle(2);
    rd(A_CAPL, v); chk("R3 capture holds", v, 1);

    // random runs
    for (int it = 0; it < 12; it++) begin
      int p, l0, h0, c0, c1, o0, o1, m;
      logic [3:0] rt;
      p  = 2 + int'($urandom % 8);
      l0 = int'($urandom % (p + 1));
      h0 = (it % 3 == 0) ? 32'hFF_FFFE : int'($urandom & 32'hFF_FFFF);
      c0 = int'($urandom % (p + 1));
      c1 = int'($urandom % (p + 1));
      o0 = (h0 + 1 + int'($urandom % 3)) & 32'hFF_FFFF;
      o1 = (h0 + 1 + int'($urandom % 3)) & 32'hFF_FFFF;
      rt = 4'($urandom);
      m  = int'($urandom % 40);
      scenario($sformatf("rand%0d", it), p, l0, h0, c0, c1, o0, o1, rt, m);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule